// File: doc/BRIEF.md
# Selectable periodic interrupt divider

This block counts a 32.768 kHz time-base enable through a 15-stage binary chain. From that chain it produces three outputs. The first is a one-clock periodic strobe at a power-of-two rate chosen by a 4-bit rate code. The second is a one-clock tick once per second for the calendar counter. The third is a square wave at the selected rate, which drives out only when enabled. A register block elsewhere owns the control fields and the interrupt masking. It feeds the rate code, the divisor code and the square-wave enable straight into this divider.

Every stage of the chain is a bit of one counter that advances on each time-base enable. Bit k toggles at 16384/2^k Hz. The selected rate picks one of these bits as the tap. The periodic strobe marks each 0-to-1 transition of the tap. The one-second tick marks each 0-to-1 transition of the top bit. Two divisor codes hold the whole chain at zero. All other divisor codes run it from the 32.768 kHz base.

Top module: `rate_divider`

## Requirements
- R1: Rate code 0 turns the periodic output off: `per_strobe` stays 0 and `sq_out` is 0.
- R2: For rate codes 3 to 15, the rate is 2^(16-code) Hz, from 8192 Hz down to 2 Hz. One period is P = 2^(code-1) enables. With n enables counted since the chain was released, `per_strobe` is 1 in the clock after the enable for which n mod P equals P/2.
- R3: Rate code 1 gives 256 Hz (P = 128) and rate code 2 gives 128 Hz (P = 256), with the same timing as R2.
- R4: While `base_sel` is 6 or 7, the chain is held at zero from the next clock edge. During the hold all three outputs are 0. After release, counting restarts from n = 0.
- R5: `base_sel` codes 0 to 5 all run the chain from the 32.768 kHz enable, each with identical behaviour.
- R6: `sec_tick` is 1 for one clock after each enable for which n mod 32768 equals 16384. The first tick therefore comes 0.5 s after release.
- R7: Each strobe lasts one clock. It appears only in the clock following a cycle in which `tick_en` was 1.
- R8: `sq_out` is 1 exactly when `sq_en` is 1, the rate code is nonzero, and (n mod P) is at least P/2. Otherwise `sq_out` is 0.
- R9: Changing the rate code does not reset the chain. The new rate's strobes follow the running count n, and the change causes no extra strobe.
- R10: While `rst_n` is low, the chain and all outputs are 0, with no wait for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-clock enable at 32.768 kHz |
| rate_sel | input | 4 | Periodic rate code |
| base_sel | input | 3 | Divisor code; 6 and 7 hold the chain |
| sq_en | input | 1 | Square-wave output enable |
| per_strobe | output | 1 | One-clock periodic strobe |
| sec_tick | output | 1 | One-clock pulse per second |
| sq_out | output | 1 | Square wave at the selected rate |

## Verification
`per_strobe` and `sec_tick` are registered, so each is due in the clock that follows the enable that raised its chain bit. `sq_out` follows the counter within the same cycle. A hold through `base_sel` takes effect at the next edge, while `rst_n` clears the outputs at once. The bench drives its inputs and compares outputs on the falling clock edge. At each falling edge it compares against an enable count n kept in the bench, advanced only after a rising edge at which `tick_en` was 1. Each expected value follows from n mod P by arithmetic, so every comparison lands half a cycle after the register update it depends on.

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int CHAIN_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [3:0] rate_sel,
  input  logic [2:0] base_sel,
  input  logic       sq_en,
  output logic       per_strobe,
  output logic       sec_tick,
  output logic       sq_out
);
  localparam int TAP_OFS = CHAIN_W - 13;

  logic [CHAIN_W-1:0] cnt;
  logic [3:0]         eff;
  logic [3:0]         tap;
  logic [CHAIN_W-1:0] lo_mask;
  logic [CHAIN_W-1:0] win;
  logic               hold, active, tap_rise, sec_rise;

  assign hold     = base_sel[2] & base_sel[1];
  assign active   = rate_sel != 4'd0;
  assign eff      = (rate_sel < 4'd3) ? rate_sel + 4'd7 : rate_sel;
  assign tap      = eff - 4'(TAP_OFS);
  assign lo_mask  = (CHAIN_W'(1) << tap) - CHAIN_W'(1);
  assign win      = {lo_mask[CHAIN_W-2:0], 1'b1};
  assign tap_rise = tick_en && ((cnt & win) == lo_mask);
  assign sec_rise = tick_en && (cnt == {1'b0, {(CHAIN_W-1){1'b1}}});
  assign sq_out   = sq_en && active && cnt[tap];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      per_strobe <= 1'b0;
      sec_tick   <= 1'b0;
    end else if (hold) begin
      cnt        <= '0;
      per_strobe <= 1'b0;
      sec_tick   <= 1'b0;
    end else begin
      if (tick_en) cnt <= cnt + CHAIN_W'(1);
      per_strobe <= active && tap_rise;
      sec_tick   <= sec_rise;
    end
  end
endmodule

// File: rtl/rate_divider_chk.sv
module rate_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic [3:0] rate_sel,
  input logic [2:0] base_sel,
  input logic       sq_en,
  input logic       per_strobe,
  input logic       sec_tick,
  input logic       sq_out
);
  AST_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    per_strobe |=> !per_strobe); // R7
  AST_STROBE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    per_strobe |-> $past(tick_en)); // R7
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(base_sel[2] && base_sel[1]) |-> (!per_strobe && !sec_tick && !sq_out)); // R4
  AST_RATE0_NO_SQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0) |-> !sq_out); // R1
  AST_RATE0_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rate_sel == 4'd0) |-> !per_strobe); // R1
  AST_SQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_en |-> !sq_out); // R8
  AST_SEC_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick); // R6
endmodule

bind rate_divider rate_divider_chk u_chk (.*);

// File: tb/rate_divider_test.sv
module rate_divider_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic [2:0] base_sel = 3'd2;
  logic       sq_en = 1'b1;
  logic       per_strobe, sec_tick, sq_out;

  int checks = 0, fails = 0;
  int n = 0;
  bit last_en = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rate_divider uut (.*);

  function automatic int period(input logic [3:0] c);
    int f;
    if (c == 4'd1) f = 256;
    else if (c == 4'd2) f = 128;
    else f = 32768 >> (c - 1);
    return 32768 / f;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s n=%0d rate=%0d actual=%0b expected=%0b", tag, n, rate_sel, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int p;
    logic es, eq, et;
    if (rate_sel == 4'd0) begin
      es = 1'b0; eq = 1'b0;
    end else begin
      p  = period(rate_sel);
      es = last_en && n > 0 && (n % p) == p / 2;
      eq = sq_en && ((n % p) >= p / 2);
    end
    et = last_en && n > 0 && (n % 32768) == 16384;
    check({tag, " strobe"}, per_strobe, es);
    check({tag, " sq R8"}, sq_out, eq);
    check("R6 sec", sec_tick, et);
  endtask

  task automatic step(input bit en);
    tick_en = en;
    @(posedge clk);
    @(negedge clk);
    if (en) n++;
    last_en = en;
  endtask

  task automatic run(input string tag, input int cycles, input int every);
    for (int i = 0; i < cycles; i++) begin
      step((i % every) == 0);
      check_all(tag);
    end
  endtask

  task automatic hold_restart(input logic [2:0] hcode, input logic [2:0] rcode);
    base_sel = hcode;
    tick_en  = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R4 hold strobe", per_strobe, 1'b0);
      check("R4 hold sec", sec_tick, 1'b0);
      check("R4 hold sq", sq_out, 1'b0);
    end
    base_sel = rcode;
    n = 0;
    last_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rate_sel = 4'd3;
    repeat (3) @(negedge clk);
    check("R10 reset strobe", per_strobe, 1'b0);
    check("R10 reset sec", sec_tick, 1'b0);
    check("R10 reset sq", sq_out, 1'b0);
    rst_n = 1'b1;

    for (int c = 0; c < 16; c++) begin
      int cyc;
      hold_restart(3'd7, 3'd2);
      rate_sel = 4'(c);
      if (c == 0) cyc = 64;
      else if (c == 15) cyc = 50000;
      else cyc = 2 * period(4'(c)) + 4;
      if (c == 0) run("R1", cyc, 1);
      else if (c < 3) run("R3", cyc, 1);
      else run("R2", cyc, 1);
    end

    hold_restart(3'd6, 3'd2);
    rate_sel = 4'd3;
    run("R7 sparse", 90, 3);

    hold_restart(3'd7, 3'd2);
    rate_sel = 4'd5;
    sq_en = 1'b0;
    run("R8 off", 200, 1);
    sq_en = 1'b1;

    for (int b = 0; b < 6; b++) begin
      if (b == 2) continue;
      hold_restart(3'd7, 3'(b));
      rate_sel = 4'd4;
      run("R5", 80, 1);
    end

    hold_restart(3'd7, 3'd2);
    rate_sel = 4'd3;
    run("R9 pre", 37, 1);
    rate_sel = 4'd9;
    run("R9 mid", 300, 1);
    rate_sel = 4'd1;
    run("R9 post", 300, 1);

    rate_sel = 4'd3;
    run("R4 pre", 10, 1);
    hold_restart(3'd6, 3'd2);
    run("R4 post", 20, 1);

    #1 rst_n = 1'b0;
    #1;
    check("R10 async strobe", per_strobe, 1'b0);
    check("R10 async sq", sq_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    last_en = 1'b0;
    run("R10 after", 20, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule